// File: doc/BRIEF.md
# Cache Line ECC Data Checker

This block walks through the four 64-bit doublewords of one cache line and checks each against the 8-bit check byte stored next to it. A single `start` pulse begins a pass. The block then asks for the doublewords one at a time over a simple read port. It drives `rdReq` together with the offset it wants, and it takes the answer in any cycle in which `rspValid` is high. Memory may answer in the same cycle as the request or any number of cycles later.

For each answer, the block builds a fresh check byte from the data within that same cycle. Check bit i is the XOR of all data bits picked out by mask i. Mask 0 is `0x0738C808099264FF`, and each later mask is the one before it rotated left by eight bits. The fresh byte is XORed with the stored byte to form a syndrome. A non-zero syndrome marks the doubleword as bad. A syndrome with exactly one set bit is counted as a single-bit error, and any other non-zero syndrome as a double-bit error.

After the fourth answer the block raises `done` for one cycle. At that point it presents a 4-bit map of bad doublewords, two sticky error flags, and the syndrome of the last bad doubleword. These results stay unchanged until the next accepted `start`. The block only reports errors and never corrects data.

Top module: `ecc_line_checker`

## Requirements
- R1: After reset, `busy`, `rdReq`, `done`, `sglErr` and `dblErr` are 0, and `badMap` and `lastSyndrome` are all zeros.
- R2: A `start` taken while idle makes `busy` and `rdReq` high from the next cycle, with `rdOffset` = 0. In that same cycle `badMap`, `sglErr`, `dblErr` and `lastSyndrome` are cleared to 0.
- R3: While busy, each cycle with `rspValid` high takes the answer for the current `rdOffset`, and the next request is for the following offset (0, 1, 2, then 3). `rspValid` is ignored while idle.
- R4: Check bit i (bit i of the check byte) is the XOR over the bits of `rspData AND mask_i`. Here mask_0 = 64'h0738C808099264FF and mask_i = mask_0 rotated left by 8*i bits. The syndrome is the computed byte XOR `rspCheck`.
- R5: `badMap` bit (3 - k) is 1 exactly when the doubleword at offset k had a non-zero syndrome. Offset 0 therefore sits in the most significant bit.
- R6: `sglErr` becomes 1 and stays 1 once any doubleword of the pass has a syndrome with exactly one set bit.
- R7: `dblErr` becomes 1 and stays 1 once any doubleword of the pass has a non-zero syndrome with two or more set bits.
- R8: One cycle after the fourth answer is taken, `done` is 1 for exactly one cycle. In that same cycle `busy` and `rdReq` are 0 and the final results are on the outputs.
- R9: `lastSyndrome` holds the syndrome of the most recent bad doubleword of the pass. A doubleword with a zero syndrome leaves it unchanged, and it stays 0 if no doubleword was bad.
- R10: A `start` that arrives while busy is ignored. The pass continues at its current offset, and the results already gathered are kept.
- R11: Once a pass ends, `badMap`, both flags and `lastSyndrome` stay unchanged until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass over one line (ignored while busy) |
| rdReq | output | 1 | Read request for the doubleword at `rdOffset` |
| rdOffset | output | 2 | Doubleword offset being requested |
| rspValid | input | 1 | Read answer present this cycle |
| rspData | input | 64 | Doubleword read back |
| rspCheck | input | 8 | Stored check byte for `rspData` |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| badMap | output | 4 | Bad-doubleword map; bit 3 is offset 0 |
| sglErr | output | 1 | Sticky single-bit error flag |
| dblErr | output | 1 | Sticky double-bit error flag |
| lastSyndrome | output | 8 | Syndrome of the most recent bad doubleword |

## Verification
The hardest case to reach from the ports is a pass that contains both error classes in different doublewords, combined with a second `start` arriving in the middle of the pass. In that case the sticky flags, the map position for each offset, and the rule that the latest bad syndrome wins must all hold at once, while the ignored start must not disturb any of them.

The stimulus builds lines from random data and their true check bytes. It then flips zero, one or two of the 72 stored bits in each doubleword. It also runs directed lines: a flip in a check bit only, a flip in two check bits at offset 0, and a flip in one data bit at offset 3. One directed pass raises `start` during a gap before the third answer. Answer latency is drawn at random, so back-to-back answers and waiting cycles both occur.

// File: rtl/ecc_line_pkg.sv
package ecc_line_pkg;

  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int ROT_STEP = DATA_W / CHK_W;
  localparam logic [DATA_W-1:0] MASK_SEED = 64'h0738C808099264FF;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic capture;
  } dpStrobe_t;

  // mask for check bit idx: seed rotated left by ROT_STEP*idx
  function automatic logic [DATA_W-1:0] rotMask(input int idx);
    logic [DATA_W-1:0] m;
    m = MASK_SEED;
    for (int s = 0; s < ROT_STEP * idx; s++) begin
      m = {m[DATA_W-2:0], m[DATA_W-1]};
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_line_ctrl.sv
module ecc_line_ctrl
  import ecc_line_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             rspValid,
  output logic             busy,
  output logic [IDX_W-1:0] wordIdx,
  output logic             done,
  output dpStrobe_t        strobe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  logic busyQ;
  logic doneQ;
  logic [IDX_W-1:0] idxQ;
  logic accept;
  logic launch;

  assign launch = start & ~busyQ;
  assign accept = busyQ & rspValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      idxQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (launch) begin
        busyQ <= 1'b1;
        idxQ  <= '0;
      end else if (accept) begin
        if (idxQ == LAST_IDX) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
          idxQ  <= '0;
        end else begin
          idxQ <= idxQ + IDX_W'(1);
        end
      end
    end
  end

  assign busy           = busyQ;
  assign done           = doneQ;
  assign wordIdx        = idxQ;
  assign strobe.clearAll = launch;
  assign strobe.capture  = accept;

  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busyQ) |=> (busyQ && idxQ == '0)); // R2
  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && rspValid && idxQ != LAST_IDX) |=> (busyQ && idxQ == $past(idxQ) + IDX_W'(1))); // R3
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && rspValid && idxQ == LAST_IDX) |=> (doneQ && !busyQ)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start && !rspValid) |=> (busyQ && $stable(idxQ))); // R10

endmodule

// File: rtl/ecc_line_dp.sv
module ecc_line_dp
  import ecc_line_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] rspData,
  input  logic [CHK_W-1:0]  rspCheck,
  output logic [NUM_WORDS-1:0] badMap,
  output logic              sglErr,
  output logic              dblErr,
  output logic [CHK_W-1:0]  lastSyndrome
);

  logic [CHK_W-1:0] calcCheck;
  logic [CHK_W-1:0] syndrome;
  logic isBad;
  logic isSingle;

  for (genvar g = 0; g < CHK_W; g++) begin : gCheck
    localparam logic [DATA_W-1:0] COL_MASK = rotMask(g);
    assign calcCheck[g] = ^(rspData & COL_MASK);
  end

  assign syndrome = calcCheck ^ rspCheck;
  assign isBad    = |syndrome;
  assign isSingle = $onehot(syndrome);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      badMap       <= '0;
      sglErr       <= 1'b0;
      dblErr       <= 1'b0;
      lastSyndrome <= '0;
    end else if (strobe.clearAll) begin
      badMap       <= '0;
      sglErr       <= 1'b0;
      dblErr       <= 1'b0;
      lastSyndrome <= '0;
    end else if (strobe.capture) begin
      for (int b = 0; b < NUM_WORDS; b++) begin
        if (wordIdx == IDX_W'(NUM_WORDS - 1 - b)) badMap[b] <= isBad;
      end
      if (isSingle) sglErr <= 1'b1;
      if (isBad && !isSingle) dblErr <= 1'b1;
      if (isBad) lastSyndrome <= syndrome;
    end
  end

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (badMap == '0 && !sglErr && !dblErr && lastSyndrome == '0)); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clearAll && !strobe.capture) |=> ($stable(badMap) && $stable(lastSyndrome))); // R11
  AST_SGL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (sglErr && !strobe.clearAll) |=> sglErr); // R6
  AST_DBL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (dblErr && !strobe.clearAll) |=> dblErr); // R7
  AST_MAP_HAS_SYN: assert property (@(posedge clk) disable iff (!rstN)
    (badMap != '0) |-> (lastSyndrome != '0)); // R9

endmodule

// File: rtl/ecc_line_checker.sv
module ecc_line_checker
  import ecc_line_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic                 rdReq,
  output logic [IDX_W-1:0]     rdOffset,
  input  logic                 rspValid,
  input  logic [DATA_W-1:0]    rspData,
  input  logic [CHK_W-1:0]     rspCheck,
  output logic                 busy,
  output logic                 done,
  output logic [NUM_WORDS-1:0] badMap,
  output logic                 sglErr,
  output logic                 dblErr,
  output logic [CHK_W-1:0]     lastSyndrome
);

  dpStrobe_t strobe;
  logic [IDX_W-1:0] wordIdx;
  logic busyInt;

  ecc_line_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rspValid (rspValid),
    .busy     (busyInt),
    .wordIdx  (wordIdx),
    .done     (done),
    .strobe   (strobe)
  );

  ecc_line_dp #(.NUM_WORDS(NUM_WORDS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wordIdx      (wordIdx),
    .rspData      (rspData),
    .rspCheck     (rspCheck),
    .badMap       (badMap),
    .sglErr       (sglErr),
    .dblErr       (dblErr),
    .lastSyndrome (lastSyndrome)
  );

  assign busy     = busyInt;
  assign rdReq    = busyInt;
  assign rdOffset = wordIdx;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && badMap == '0 && !sglErr && !dblErr)); // R1

endmodule

// File: tb/ecc_line_checker_tb.sv
`timescale 1ns/1ps
module ecc_line_checker_tb;

  localparam logic [63:0] SEED_MASK = 64'h0738C808099264FF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, start, rspValid;
  logic [63:0] rspData;
  logic [7:0] rspCheck;
  logic rdReq, busy, done, sglErr, dblErr;
  logic [1:0] rdOffset;
  logic [3:0] badMap;
  logic [7:0] lastSyndrome;

  ecc_line_checker u_dut (
    .clk(clk), .rstN(rstN), .start(start), .rdReq(rdReq), .rdOffset(rdOffset),
    .rspValid(rspValid), .rspData(rspData), .rspCheck(rspCheck), .busy(busy),
    .done(done), .badMap(badMap), .sglErr(sglErr), .dblErr(dblErr),
    .lastSyndrome(lastSyndrome)
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] lineData [4];
  logic [7:0]  lineChk  [4];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R4: bit i = parity of data under seed rotated left by 8*i
  function automatic logic [7:0] refEcc(input logic [63:0] d);
    logic [7:0] p = '0;
    for (int i = 0; i < 8; i++)
      for (int b = 0; b < 64; b++)
        if (d[b] && SEED_MASK[(b + 64 - 8 * i) % 64]) p[i] = ~p[i];
    return p;
  endfunction

  task automatic flipBit(input int k, input int pos);
    if (pos < 64) lineData[k][pos] = ~lineData[k][pos];
    else lineChk[k][pos - 64] = ~lineChk[k][pos - 64];
  endtask

  task automatic cleanLine();
    for (int k = 0; k < 4; k++) begin
      lineData[k] = {$urandom, $urandom};
      lineChk[k]  = refEcc(lineData[k]);
    end
  endtask

  task automatic runLine(input bit midStart, input string tag);
    logic [3:0] expMap = '0;
    logic expSgl = 0, expDbl = 0;
    logic [7:0] expSyn = '0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] s = refEcc(lineData[k]) ^ lineChk[k];
      if (s != 0) begin
        expMap[3 - k] = 1'b1;
        expSyn = s;
        if ($countones(s) == 1) expSgl = 1'b1; else expDbl = 1'b1;
      end
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", {tag, " busy after start"}, busy, 1);
    chk("R2", {tag, " rdReq after start"}, rdReq, 1);
    chk("R2", {tag, " map cleared"}, badMap, 0);
    chk("R2", {tag, " flags cleared"}, {sglErr, dblErr}, 0);
    chk("R2", {tag, " syndrome cleared"}, lastSyndrome, 0);
    for (int k = 0; k < 4; k++) begin
      int gap = $urandom_range(0, 2);
      if (midStart && k == 2) gap = 1;
      for (int g = 0; g < gap; g++) begin
        start = (midStart && k == 2);
        @(negedge clk);
        start = 1'b0;
      end
      rspValid = 1'b1; rspData = lineData[k]; rspCheck = lineChk[k];
      chk(midStart ? "R10" : "R3", {tag, " offset"}, rdOffset, k);
      @(negedge clk);
      rspValid = 1'b0;
      if (k < 3) chk("R8", {tag, " done early"}, done, 0);
    end
    chk("R8", {tag, " done pulse"}, done, 1);
    chk("R8", {tag, " idle at done"}, {busy, rdReq}, 0);
    chk("R5", {tag, " bad map"}, badMap, expMap);
    chk("R6", {tag, " single flag"}, sglErr, expSgl);
    chk("R7", {tag, " double flag"}, dblErr, expDbl);
    chk("R9", {tag, " last syndrome"}, lastSyndrome, expSyn);
    // idle answers must change nothing
    rspValid = 1'b1; rspData = {$urandom, $urandom}; rspCheck = 8'hA5;
    @(negedge clk);
    chk("R8", {tag, " done one cycle"}, done, 0);
    @(negedge clk);
    rspValid = 1'b0;
    chk("R3", {tag, " idle rsp ignored busy"}, busy, 0);
    chk("R11", {tag, " map held"}, badMap, expMap);
    chk("R11", {tag, " flags held"}, {sglErr, dblErr}, {expSgl, expDbl});
    chk("R11", {tag, " syndrome held"}, lastSyndrome, expSyn);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual 0 expected 1 (run never ended)");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED));
    rstN = 1'b0; start = 1'b0; rspValid = 1'b0; rspData = '0; rspCheck = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset busy/req/done", {busy, rdReq, done}, 0);
    chk("R1", "reset map", badMap, 0);
    chk("R1", "reset flags", {sglErr, dblErr}, 0);
    chk("R1", "reset syndrome", lastSyndrome, 0);
    rstN = 1'b1;
    @(negedge clk);

    cleanLine();
    runLine(0, "clean");
    cleanLine();
    for (int k = 0; k < 4; k++) flipBit(k, 64 + k);
    runLine(0, "chk1bit");
    cleanLine();
    flipBit(0, 64); flipBit(0, 71);
    runLine(0, "dbl_off0");
    cleanLine();
    flipBit(3, 17);
    runLine(0, "data_off3");
    cleanLine();
    flipBit(0, 66); flipBit(1, 3); flipBit(1, 40); flipBit(3, 69);
    runLine(1, "mid_start");

    for (int n = 0; n < 60; n++) begin
      cleanLine();
      for (int k = 0; k < 4; k++) begin
        int kind = $urandom_range(0, 2);
        int p1 = $urandom_range(0, 71);
        int p2 = (p1 + $urandom_range(1, 71)) % 72;
        if (kind >= 1) flipBit(k, p1);
        if (kind == 2) flipBit(k, p2);
      end
      runLine(0, "random");
    end
    finishRun();
  end

endmodule